// File: doc/BRIEF.md
# Symbol Timing Recovery Loop with Gray Bit Demapper

This block recovers the symbol clock from a stream of per-sample phase-shift codes produced by a differential phase detector, and turns each recovered symbol into serial data bits. A signed phase accumulator advances by a programmable step on every accepted sample. When the accumulator passes from a non-negative value to a negative one, the current code is taken as the symbol. The code is translated through a Gray table and shifted out one bit per clock, most significant bit first.

Timing is corrected whenever the incoming code differs from the code of the previous accepted sample. The accumulator is then scaled toward zero by a fractional inertia factor. A downstream frame decoder reports through a status input whether it is collecting a frame. While it is, the gentler locked inertia is used. Otherwise the stronger searching inertia applies. Either four-phase (2 bits per symbol) or eight-phase (3 bits per symbol) operation is selected by an input.

Top module: `sym_timing_pll`

## Requirements
- R1: After a synchronous reset, `phase_out` is 0, `bit_valid` is 0, `smp_ready` is 1, and the stored previous code is 0.
- R2: Each accepted sample (`smp_valid` and `smp_ready` both high) adds `step_inc` to the accumulator, modulo 2^32 in two's complement. `phase_out` shows the result one clock later.
- R3: A symbol is taken only on an accepted sample where the accumulator is non-negative before the add and negative after it. The first data bit appears on `bit_out` with `bit_valid` high in the following cycle.
- R4: In four-phase mode (`oct_mode`=0), codes 0,1,2,3 map to bit pairs 00,01,11,10. The two bits leave on consecutive cycles, left bit first.
- R5: In eight-phase mode (`oct_mode`=1), codes 0..7 map to 3-bit values 1,0,2,3,7,6,4,5. The three bits leave on consecutive cycles, most significant first.
- R6: When an accepted code differs from the previous accepted code, the post-add value is replaced by floor(value × inertia / 65536). Otherwise the post-add value is kept. The sign never changes.
- R7: The inertia is `inert_lock` when `gathering` is high and `inert_seek` when it is low. Both are unsigned fractions with 16 fraction bits.
- R8: The wrap test uses the value before correction, so a symbol and a correction can occur on the same sample. The previous code is updated on every accepted sample.
- R9: `smp_ready` is low while symbol bits are being shifted out. A sample offered then changes neither the accumulator nor the stored previous code, and it emits no bits.
- R10: In four-phase mode, bit 2 of `smp_code` is ignored for both mapping and change detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | A phase-shift code is offered this cycle |
| smp_code | input | 3 | Phase-shift code of the sample |
| oct_mode | input | 1 | 1: eight-phase, 3 bits per symbol; 0: four-phase, 2 bits |
| step_inc | input | 32 | Accumulator step per sample, round(2^32 × symbol rate / sample rate) |
| inert_lock | input | 16 | Inertia used while a frame is being gathered |
| inert_seek | input | 16 | Inertia used while searching |
| gathering | input | 1 | Downstream is collecting a frame |
| smp_ready | output | 1 | Block accepts a sample this cycle |
| phase_out | output | 32 | Current accumulator value |
| bit_valid | output | 1 | `bit_out` carries a data bit |
| bit_out | output | 1 | Serial data bit, MSB of each symbol first |

## Verification
The wrap that takes a symbol and the inertia correction triggered by a code change can land on the same sample. In that case the bits must come from the code at the wrap, and the wrap test must use the uncorrected sum. The vector walk reaches this case by changing the code on the exact sample whose add crosses into negative values. It then checks both the emitted bit pair and the scaled accumulator value in the following cycles. A separate test offers a code during the shift-out burst and then checks, through the size of the next correction, that the stored previous code was not altered.

// File: rtl/sym_pll_pkg.sv
package sym_pll_pkg;

   // number of serial bits per symbol, by mode
   localparam int unsigned QUAD_BITS = 2;
   localparam int unsigned OCT_BITS  = 3;

   typedef enum logic {
      MAP_QUAD = 1'b0,
      MAP_OCT  = 1'b1
   } map_mode_e;

   // four-phase Gray translation, result right-aligned in 2 bits
   function automatic logic [1:0] gray_quad(input logic [1:0] code);
      logic [1:0] g;
      case (code)
         2'd0:    g = 2'b00;
         2'd1:    g = 2'b01;
         2'd2:    g = 2'b11;
         default: g = 2'b10;
      endcase
      return g;
   endfunction

   // eight-phase Gray translation
   function automatic logic [2:0] gray_oct(input logic [2:0] code);
      logic [2:0] g;
      case (code)
         3'd0:    g = 3'd1;
         3'd1:    g = 3'd0;
         3'd2:    g = 3'd2;
         3'd3:    g = 3'd3;
         3'd4:    g = 3'd7;
         3'd5:    g = 3'd6;
         3'd6:    g = 3'd4;
         default: g = 3'd5;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/sym_phase_acc.sv
module sym_phase_acc #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned FRAC_W = 16,
   parameter int unsigned CODE_W = 3
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     take,
   input  logic [CODE_W-1:0]        code_m,
   input  logic [ACC_W-1:0]         step,
   input  logic [FRAC_W-1:0]        inertia,
   output logic signed [ACC_W-1:0]  acc,
   output logic                     wrap
);

   localparam int unsigned PROD_W = ACC_W + FRAC_W + 1;

   logic signed [ACC_W-1:0]  acc_q;
   logic [CODE_W-1:0]        prev_q;
   logic signed [ACC_W-1:0]  sum;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  shrunk;
   logic                     changed;

   always_comb begin
      sum     = acc_q + $signed(step);
      wrap    = take && !acc_q[ACC_W-1] && sum[ACC_W-1];
      changed = (code_m != prev_q);
      prod    = $signed({{(FRAC_W+1){sum[ACC_W-1]}}, sum})
              * $signed({{(ACC_W+1){1'b0}}, inertia});
      // dropping the fraction bits of a two's complement product floors it
      shrunk  = prod[FRAC_W +: ACC_W];
   end

   wire unused_prod_bits = ^{prod[PROD_W-1], prod[FRAC_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         prev_q <= '0;
      end else if (take) begin
         acc_q  <= changed ? shrunk : sum;
         prev_q <= code_m;
      end
   end

   assign acc = acc_q;

endmodule

// File: rtl/sym_gray_map.sv
module sym_gray_map
   import sym_pll_pkg::*;
#(
   parameter bit OCT_EN = 1'b1
) (
   input  logic [2:0] code,
   input  logic       oct_mode,
   output logic [2:0] code_m,
   output logic [2:0] sym_bits,
   output logic [1:0] sym_len
);

   generate
      if (OCT_EN) begin : g_both
         map_mode_e mode;
         always_comb begin
            mode = map_mode_e'(oct_mode);
            if (mode == MAP_OCT) begin
               code_m   = code;
               sym_bits = gray_oct(code);
               sym_len  = 2'(OCT_BITS);
            end else begin
               code_m   = {1'b0, code[1:0]};
               sym_bits = {gray_quad(code[1:0]), 1'b0};
               sym_len  = 2'(QUAD_BITS);
            end
         end
      end else begin : g_quad
         wire unused_mode = oct_mode ^ code[2];
         always_comb begin
            code_m   = {1'b0, code[1:0]};
            sym_bits = {gray_quad(code[1:0]), 1'b0};
            sym_len  = 2'(QUAD_BITS);
         end
      end
   endgenerate

endmodule

// File: rtl/sym_bit_shifter.sv
module sym_bit_shifter #(
   parameter int unsigned MAX_BITS = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic [MAX_BITS-1:0] bits_in,
   input  logic [1:0]          len_in,
   output logic                busy,
   output logic                bit_valid,
   output logic                bit_out
);

   logic [MAX_BITS-1:0] sh_q;
   logic [1:0]          cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= bits_in;
         cnt_q <= len_in;
      end else if (cnt_q != 2'd0) begin
         sh_q  <= {sh_q[MAX_BITS-2:0], 1'b0};
         cnt_q <= cnt_q - 2'd1;
      end
   end

   assign busy      = (cnt_q != 2'd0);
   assign bit_valid = busy;
   assign bit_out   = sh_q[MAX_BITS-1];

endmodule

// File: rtl/sym_timing_pll.sv
module sym_timing_pll #(
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned FRAC_W = 16,
   parameter bit          OCT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              smp_valid,
   input  logic [2:0]        smp_code,
   input  logic              oct_mode,
   input  logic [ACC_W-1:0]  step_inc,
   input  logic [FRAC_W-1:0] inert_lock,
   input  logic [FRAC_W-1:0] inert_seek,
   input  logic              gathering,
   output logic              smp_ready,
   output logic [ACC_W-1:0]  phase_out,
   output logic              bit_valid,
   output logic              bit_out
);

   localparam int unsigned CODE_W = 3;

   generate
      if (ACC_W < 8) begin : g_bad_acc
         $error("sym_timing_pll: ACC_W too small");
      end
      if (FRAC_W < 2 || FRAC_W >= ACC_W) begin : g_bad_frac
         $error("sym_timing_pll: FRAC_W must lie between 2 and ACC_W-1");
      end
   endgenerate

   logic                    take;
   logic                    wrap;
   logic                    busy;
   logic [CODE_W-1:0]       code_m;
   logic [CODE_W-1:0]       sym_bits;
   logic [1:0]              sym_len;
   logic [FRAC_W-1:0]       inertia;
   logic signed [ACC_W-1:0] acc;

   assign smp_ready = !busy;
   assign take      = smp_valid && smp_ready;
   assign inertia   = gathering ? inert_lock : inert_seek;

   sym_gray_map #(.OCT_EN(OCT_EN)) u_map (
      .code     (smp_code),
      .oct_mode (oct_mode),
      .code_m   (code_m),
      .sym_bits (sym_bits),
      .sym_len  (sym_len)
   );

   sym_phase_acc #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .CODE_W(CODE_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .take    (take),
      .code_m  (code_m),
      .step    (step_inc),
      .inertia (inertia),
      .acc     (acc),
      .wrap    (wrap)
   );

   sym_bit_shifter #(.MAX_BITS(CODE_W)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (wrap),
      .bits_in   (sym_bits),
      .len_in    (sym_len),
      .busy      (busy),
      .bit_valid (bit_valid),
      .bit_out   (bit_out)
   );

   assign phase_out = acc;

endmodule

// File: rtl/sym_timing_pll_chk.sv
module sym_timing_pll_chk #(
   parameter int unsigned ACC_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             smp_valid,
   input logic             oct_mode,
   input logic [ACC_W-1:0] step_inc,
   input logic             smp_ready,
   input logic [ACC_W-1:0] phase_out,
   input logic             bit_valid
);

   logic             take_c;
   logic [ACC_W-1:0] sum_c;
   logic             sum_neg;

   assign take_c  = smp_valid && smp_ready;
   assign sum_c   = phase_out + step_inc;
   assign sum_neg = sum_c[ACC_W-1];

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (phase_out == '0) && !bit_valid && smp_ready);

   // R3
   wrap_emits_chk: assert property (@(posedge clk) disable iff (rst)
      (take_c && !phase_out[ACC_W-1] && sum_neg) |=> bit_valid);

   // R3
   burst_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bit_valid) |-> $past(take_c));

   // R6
   sign_kept_chk: assert property (@(posedge clk) disable iff (rst)
      take_c |=> (phase_out[ACC_W-1] == $past(sum_neg)));

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_valid && !smp_ready) |=> $stable(phase_out));

   // R4
   quad_burst_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(bit_valid) && !$past(oct_mode)) |=> bit_valid ##1 !bit_valid);

   // R5
   oct_burst_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(bit_valid) && $past(oct_mode)) |=> bit_valid ##1 bit_valid ##1 !bit_valid);

endmodule

bind sym_timing_pll sym_timing_pll_chk #(.ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .smp_valid (smp_valid),
   .oct_mode  (oct_mode),
   .step_inc  (step_inc),
   .smp_ready (smp_ready),
   .phase_out (phase_out),
   .bit_valid (bit_valid)
);

// File: tb/test_sym_timing_pll.sv
module test_sym_timing_pll;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_valid = 1'b0;
   logic [2:0]  smp_code = 3'd0;
   logic        oct_mode = 1'b0;
   logic [31:0] step_inc = 32'h2000_0000;
   logic [15:0] inert_lock = 16'hE000;
   logic [15:0] inert_seek = 16'h8000;
   logic        gathering = 1'b0;
   logic        smp_ready;
   logic [31:0] phase_out;
   logic        bit_valid;
   logic        bit_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   sym_timing_pll i_sym_timing_pll (
      .clk        (clk),
      .rst        (rst),
      .smp_valid  (smp_valid),
      .smp_code   (smp_code),
      .oct_mode   (oct_mode),
      .step_inc   (step_inc),
      .inert_lock (inert_lock),
      .inert_seek (inert_seek),
      .gathering  (gathering),
      .smp_ready  (smp_ready),
      .phase_out  (phase_out),
      .bit_valid  (bit_valid),
      .bit_out    (bit_out)
   );

   // row: oct, gathering, code, expected phase, expected bit count, expected bits
   localparam int NV = 27;
   localparam logic [41:0] VEC [0:NV-1] = '{
      {1'b0, 1'b0, 3'd0, 32'h2000_0000, 2'd0, 3'b000},
      {1'b0, 1'b0, 3'd0, 32'h4000_0000, 2'd0, 3'b000},
      {1'b0, 1'b0, 3'd1, 32'h3000_0000, 2'd0, 3'b000},
      {1'b0, 1'b0, 3'd1, 32'h5000_0000, 2'd0, 3'b000},
      {1'b0, 1'b0, 3'd1, 32'h7000_0000, 2'd0, 3'b000},
      {1'b0, 1'b0, 3'd1, 32'h9000_0000, 2'd2, 3'b001},
      {1'b0, 1'b1, 3'd2, 32'hBA00_0000, 2'd0, 3'b000},
      {1'b0, 1'b1, 3'd2, 32'hDA00_0000, 2'd0, 3'b000},
      {1'b0, 1'b1, 3'd3, 32'hFAC0_0000, 2'd0, 3'b000},
      {1'b0, 1'b1, 3'd3, 32'h1AC0_0000, 2'd0, 3'b000},
      {1'b0, 1'b1, 3'd3, 32'h3AC0_0000, 2'd0, 3'b000},
      {1'b0, 1'b1, 3'd3, 32'h5AC0_0000, 2'd0, 3'b000},
      {1'b0, 1'b1, 3'd3, 32'h7AC0_0000, 2'd0, 3'b000},
      {1'b0, 1'b1, 3'd2, 32'hA768_0000, 2'd2, 3'b011},
      {1'b1, 1'b0, 3'd4, 32'hE3B4_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd4, 32'h03B4_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd4, 32'h23B4_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd4, 32'h43B4_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd4, 32'h63B4_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd4, 32'h83B4_0000, 2'd3, 3'b111},
      {1'b1, 1'b0, 3'd0, 32'hD1DA_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd0, 32'hF1DA_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd0, 32'h11DA_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd0, 32'h31DA_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd0, 32'h51DA_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd0, 32'h71DA_0000, 2'd0, 3'b000},
      {1'b1, 1'b0, 3'd0, 32'h91DA_0000, 2'd3, 3'b001}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      smp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // offers one sample, then gathers any serial bits until ready returns
   task automatic do_sample(input logic m, input logic g, input logic [2:0] c,
                            output logic [31:0] ph, output logic [2:0] bits,
                            output int nb);
      @(negedge clk);
      oct_mode  = m;
      gathering = g;
      smp_code  = c;
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      ph   = phase_out;
      bits = 3'b000;
      nb   = 0;
      for (int k = 0; k < 8 && !smp_ready; k++) begin
         if (bit_valid) begin
            bits = {bits[1:0], bit_out};
            nb++;
         end
         @(negedge clk);
      end
   endtask

   function automatic logic [2:0] model_gray(input logic m, input logic [2:0] c);
      logic [2:0] quad [0:3];
      logic [2:0] oct  [0:7];
      quad = '{3'd0, 3'd1, 3'd3, 3'd2};
      oct  = '{3'd1, 3'd0, 3'd2, 3'd3, 3'd7, 3'd6, 3'd4, 3'd5};
      return m ? oct[c] : quad[c[1:0]];
   endfunction

   initial begin : watchdog
      #(200000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] ph;
      logic [2:0]  bits;
      int          nb;

      do_reset();
      @(negedge clk);
      // R1 reset state
      check("R1 phase", phase_out, 32'h0);
      check("R1 bit_valid", {31'b0, bit_valid}, 32'h0);
      check("R1 ready", {31'b0, smp_ready}, 32'h1);

      // vector walk: R2 R3 R4 R5 R6 R7 R8
      step_inc = 32'h2000_0000;
      for (int i = 0; i < NV; i++) begin
         logic [41:0] v;
         v = VEC[i];
         do_sample(v[41], v[40], v[39:37], ph, bits, nb);
         check($sformatf("R2/R6/R7 phase row %0d", i), ph, v[36:5]);
         check($sformatf("R3/R8 bit count row %0d", i), nb, {30'b0, v[4:3]});
         if (v[4:3] != 2'd0)
            check($sformatf("R4/R5 bits row %0d", i), {29'b0, bits}, {29'b0, v[2:0]});
      end

      // gray sweep, each code forced to wrap on the first sample: R4 R5 R3
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < (m ? 8 : 4); c++) begin
            do_reset();
            step_inc = 32'h8000_0000;
            do_sample(m[0], 1'b0, c[2:0], ph, bits, nb);
            check($sformatf("R4/R5 code %0d mode %0d bits", c, m),
                  {29'b0, bits}, {29'b0, model_gray(m[0], c[2:0])});
            check($sformatf("R4/R5 code %0d mode %0d count", c, m), nb, m ? 3 : 2);
            check($sformatf("R6 code %0d mode %0d phase", c, m), ph,
                  (c == 0) ? 32'h8000_0000 : 32'hC000_0000);
         end
      end

      // R9 sample offered while busy is ignored
      do_reset();
      oct_mode  = 1'b0;
      gathering = 1'b0;
      step_inc  = 32'h8000_0000;
      @(negedge clk);
      smp_code  = 3'd0;
      smp_valid = 1'b1;
      @(negedge clk);
      check("R9 ready low during burst", {31'b0, smp_ready}, 32'h0);
      smp_code  = 3'd3;
      @(negedge clk);
      smp_valid = 1'b0;
      check("R9 phase untouched", phase_out, 32'h8000_0000);
      for (int k = 0; k < 8 && !smp_ready; k++) @(negedge clk);
      step_inc = 32'h1000_0000;
      do_sample(1'b0, 1'b0, 3'd3, ph, bits, nb);
      check("R9 previous code untouched", ph, 32'hC800_0000);
      check("R9 no extra bits", nb, 0);

      // R6 floor keeps the sign at minus one, and zeroes plus one
      do_reset();
      step_inc = 32'hFFFF_FFFF;
      do_sample(1'b0, 1'b0, 3'd1, ph, bits, nb);
      check("R6 floor negative", ph, 32'hFFFF_FFFF);
      check("R3 wrap at minus one", nb, 2);
      do_reset();
      step_inc = 32'h0000_0001;
      do_sample(1'b0, 1'b0, 3'd1, ph, bits, nb);
      check("R6 floor positive", ph, 32'h0);

      // R10 bit 2 ignored in four-phase mode
      do_reset();
      step_inc = 32'h1000_0000;
      do_sample(1'b0, 1'b0, 3'd4, ph, bits, nb);
      check("R10 code 4 equals 0", ph, 32'h1000_0000);
      do_sample(1'b0, 1'b0, 3'd1, ph, bits, nb);
      check("R10 change halves", ph, 32'h1000_0000);
      do_sample(1'b0, 1'b0, 3'd5, ph, bits, nb);
      check("R10 code 5 equals 1", ph, 32'h2000_0000);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule